// File: doc/BRIEF.md
# Security-Register Erase Controller for a Serial Flash

This block is the slave-side command logic of a serial flash device for the part of the command set that wipes one of three 256-byte one-time-programmable security areas. The host clocks SPI mode-0 frames into it while chip select is low. The block keeps the write-enable latch, the write-in-progress flag and three lock flags. It reports these flags through the status-read command. A valid erase frame starts a self-timed cycle. During that cycle the chosen area is filled with 0xFF, one byte per system clock.

All SPI pins are sampled on the system clock, so the SPI clock must run well below the system clock. A frame counts only when chip select is released exactly after its last bit. A rejected frame is dropped with no trace: no status bit changes and no storage byte changes. A sideband read port gives direct access to every stored byte.

Top module: `sec_reg_erase`

## Requirements
- R1: After reset the status byte holds only the lock flags, SO is low and every stored byte reads 0x00.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable flag (status bit 1). A frame with that opcode but any other bit count leaves the flag unchanged.
- R3: After the 8 bits of opcode 0x05, SO shifts out the status byte MSB first, changing on falling SCK edges, and repeats the byte for as long as chip select stays low. The layout is bit 0 write-in-progress, bit 1 write-enable, bits 3, 4 and 5 the lock flags of areas 1, 2 and 3, all other bits 0. While chip select is high SO is 0.
- R4: A 32-bit frame of opcode 0x44 followed by a 24-bit address, both MSB first, that passes every check starts the erase on the chip-select rise. At that moment write-in-progress goes to 1 and write-enable goes to 0. Write-in-progress stays 1 for max(ERASE_CYCLES, 256) system clocks.
- R5: A completed erase leaves all 256 bytes of the selected area at 0xFF and leaves the other areas unchanged.
- R6: The address selects area n when bits 23..16 are 0x00, bits 11..8 are 0 and bits 15..12 equal n (1, 2 or 3). Bits 7..0 are ignored. Any other address makes the erase a no-op and the write-enable flag stays set.
- R7: An erase frame with any bit count other than 32 is ignored.
- R8: An erase frame sent while the write-enable flag is clear is ignored.
- R9: The lock flags come from the LOCK_INIT parameter and never change. An erase aimed at a locked area is ignored and the write-enable flag stays set.
- R10: While write-in-progress is 1, write-enable and erase frames are ignored, so the write-enable flag reads 0 after the cycle ends.
- R11: The sideband port returns the byte at rd_addr of area rd_sel (1 to 3) combinationally, and returns 0x00 for rd_sel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial status data to host |
| rd_sel | input | 2 | Sideband area select (1 to 3) |
| rd_addr | input | 8 | Sideband byte index |
| rd_data | output | 8 | Sideband byte value |

## Verification
The bench builds the block with ERASE_CYCLES = 300 and LOCK_INIT = 3'b010. The short cycle lets the bench wait out a full erase and also catch write-in-progress still set during a status read that starts right after the accepting edge. Locking only area 2 means one build covers both the locked-area rejection and successful erases of areas 1 and 3.

// File: rtl/sr_erase_pkg.sv
package sr_erase_pkg;

    localparam int SR_COUNT   = 3;
    localparam int SR_BYTES   = 256;
    localparam int IDX_W      = $clog2(SR_BYTES);
    localparam int SEL_W      = 2;
    localparam int BITCNT_W   = 6;
    localparam int FRAME_BITS = 32;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_ERASE = 8'h44;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic [1:0]          spare_hi;
        logic [SR_COUNT-1:0] lock;
        logic                spare_lo;
        logic                wel;
        logic                wip;
    } status_t;

    // Upper address bits 23..8 to area number, 0 when no area matches.
    function automatic sel_t decode_area(input logic [15:0] a_hi);
        sel_t r;
        r = '0;
        if (a_hi[15:8] == 8'h00 && a_hi[3:0] == 4'h0 &&
            a_hi[7:4] != 4'h0 && 32'(a_hi[7:4]) <= SR_COUNT)
            r = sel_t'(a_hi[7:4]);
        return r;
    endfunction

endpackage

// File: rtl/sr_spi_rx.sv
module sr_spi_rx
    import sr_erase_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sck,
    input  logic                si,
    input  status_t             status,
    output logic                so,
    output logic                frame_end,
    output logic [BITCNT_W-1:0] frame_bits,
    output logic [FRAME_BITS-1:0] frame_word
);

    logic                  sck_q, cs_q;
    logic [BITCNT_W-1:0]   bitcnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [7:0]            op_q;
    logic [2:0]            so_idx;
    logic                  so_q;
    logic                  sck_rise, sck_fall, rdsr_on;

    assign sck_rise  = !cs_n && sck && !sck_q;
    assign sck_fall  = !cs_n && !sck && sck_q;
    assign rdsr_on   = (op_q == OP_RDSR) && (bitcnt >= BITCNT_W'(8));
    assign frame_end = cs_n && !cs_q;
    assign frame_bits = bitcnt;
    assign frame_word = shreg;
    assign so        = so_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            bitcnt <= '0;
            shreg  <= '0;
            op_q   <= '0;
            so_idx <= '0;
            so_q   <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bitcnt <= '0;
                so_idx <= '0;
                so_q   <= 1'b0;
                op_q   <= '0;
            end else begin
                if (sck_rise) begin
                    shreg <= {shreg[FRAME_BITS-2:0], si};
                    if (bitcnt != '1)
                        bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == BITCNT_W'(7))
                        op_q <= {shreg[6:0], si};
                end
                if (sck_fall && rdsr_on) begin
                    so_q   <= status[3'd7 - so_idx];
                    so_idx <= so_idx + 1'b1;
                end
            end
        end
    end

    // R3: output is quiet one cycle after chip select is seen high
    a_r3_so_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !so);
    // R7: the bit counter restarts after every frame end
    a_r7_count_restart: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> frame_bits == '0);

endmodule

// File: rtl/sr_erase_ctrl.sv
module sr_erase_ctrl
    import sr_erase_pkg::*;
#(
    parameter int ERASE_CYCLES = 4096,
    parameter logic [SR_COUNT-1:0] LOCK_INIT = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_end,
    input  logic [BITCNT_W-1:0]   frame_bits,
    input  logic [FRAME_BITS-1:0] frame_word,
    output status_t               status,
    output sel_t                  erase_sel,
    output logic                  erase_we,
    output logic [IDX_W-1:0]      erase_idx
);

    localparam int RUN  = (ERASE_CYCLES < SR_BYTES) ? SR_BYTES : ERASE_CYCLES;
    localparam int CW   = $clog2(RUN + 1);

    logic                wip, wel;
    logic [SR_COUNT-1:0] lock_q;
    logic [CW-1:0]       cnt;
    sel_t                sel_q, sel_d;
    logic                target_locked, accept, wren_ok;

    assign sel_d = decode_area(frame_word[23:8]);

    always_comb begin
        target_locked = 1'b0;
        for (int i = 0; i < SR_COUNT; i++)
            if (sel_d == sel_t'(i + 1)) target_locked = lock_q[i];
    end

    assign accept = frame_end && !wip && wel &&
                    frame_bits == BITCNT_W'(FRAME_BITS) &&
                    frame_word[31:24] == OP_ERASE &&
                    sel_d != '0 && !target_locked;

    assign wren_ok = frame_end && !wip &&
                     frame_bits == BITCNT_W'(8) &&
                     frame_word[7:0] == OP_WREN;

    always_ff @(posedge clk) begin
        if (rst) begin
            wip    <= 1'b0;
            wel    <= 1'b0;
            cnt    <= '0;
            sel_q  <= '0;
            lock_q <= LOCK_INIT;
        end else begin
            if (accept) begin
                wip   <= 1'b1;
                wel   <= 1'b0;
                cnt   <= '0;
                sel_q <= sel_d;
            end else if (wip) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(RUN - 1))
                    wip <= 1'b0;
            end
            if (wren_ok)
                wel <= 1'b1;
        end
    end

    assign status    = '{spare_hi: 2'b00, lock: lock_q, spare_lo: 1'b0,
                         wel: wel, wip: wip};
    assign erase_sel = sel_q;
    assign erase_we  = wip && (cnt < CW'(SR_BYTES));
    assign erase_idx = cnt[IDX_W-1:0];

    // R4: the write-enable flag is already clear when the cycle begins
    a_r4_wel_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> !wel);
    // R10: no write-enable while busy
    a_r10_busy_no_wel: assert property (@(posedge clk) disable iff (rst)
        wip |-> !wel);
    // R4: the busy flag rises only on a chip-select release
    a_r4_start_on_cs: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(frame_end));
    // R9: never write into a locked area
    a_r9_no_locked_write: assert property (@(posedge clk) disable iff (rst)
        erase_we |-> !lock_q[erase_sel - 2'd1]);
    // R6: busy implies a legal area number
    a_r6_sel_legal: assert property (@(posedge clk) disable iff (rst)
        wip |-> (erase_sel != '0));

endmodule

// File: rtl/sr_store.sv
module sr_store
    import sr_erase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  sel_t             wsel,
    input  logic [IDX_W-1:0] widx,
    input  sel_t             rsel,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] bank_rd [SR_COUNT];

    for (genvar g = 0; g < SR_COUNT; g++) begin : g_bank
        logic [7:0] mem [SR_BYTES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < SR_BYTES; j++)
                    mem[j] <= 8'h00;
            end else if (we && wsel == sel_t'(g + 1)) begin
                mem[widx] <= 8'hFF;
            end
        end

        assign bank_rd[g] = mem[raddr];
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < SR_COUNT; i++)
            if (rsel == sel_t'(i + 1)) rdata = bank_rd[i];
    end

    // R5: writes always name an existing area
    a_r5_write_target: assert property (@(posedge clk) disable iff (rst)
        we |-> (wsel != '0 && 32'(wsel) <= SR_COUNT));

endmodule

// File: rtl/sec_reg_erase.sv
module sec_reg_erase
    import sr_erase_pkg::*;
#(
    parameter int ERASE_CYCLES = 4096,
    parameter logic [SR_COUNT-1:0] LOCK_INIT = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_si,
    output logic       spi_so,
    input  logic [1:0] rd_sel,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);

    status_t               status;
    logic                  frame_end;
    logic [BITCNT_W-1:0]   frame_bits;
    logic [FRAME_BITS-1:0] frame_word;
    sel_t                  erase_sel;
    logic                  erase_we;
    logic [IDX_W-1:0]      erase_idx;

    sr_spi_rx u_rx (
        .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_si),
        .status(status), .so(spi_so), .frame_end(frame_end),
        .frame_bits(frame_bits), .frame_word(frame_word)
    );

    sr_erase_ctrl #(.ERASE_CYCLES(ERASE_CYCLES), .LOCK_INIT(LOCK_INIT)) u_ctrl (
        .clk(clk), .rst(rst), .frame_end(frame_end), .frame_bits(frame_bits),
        .frame_word(frame_word), .status(status), .erase_sel(erase_sel),
        .erase_we(erase_we), .erase_idx(erase_idx)
    );

    sr_store u_store (
        .clk(clk), .rst(rst), .we(erase_we), .wsel(erase_sel),
        .widx(erase_idx), .rsel(rd_sel), .raddr(rd_addr), .rdata(rd_data)
    );

endmodule

// File: tb/sim_sec_reg_erase.sv
module sim_sec_reg_erase;

    localparam int E = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic       so;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sec_reg_erase #(.ERASE_CYCLES(E), .LOCK_INIT(3'b010)) u0 (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [39:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i]; sck = 1'b0; tick(2);
            sck = 1'b1; tick(2);
        end
    endtask

    task automatic frame(input logic [39:0] v, input int n);
        cs_n = 1'b0; tick(2);
        shift_bits(v, n);
        sck = 1'b0; tick(2);
        cs_n = 1'b1; tick(2);
    endtask

    task automatic read_status(output logic [7:0] b);
        cs_n = 1'b0; tick(2);
        shift_bits(40'h05, 8);
        for (int k = 0; k < 8; k++) begin
            sck = 1'b0; tick(2);
            b[7-k] = so;
            sck = 1'b1; tick(2);
        end
        sck = 1'b0; tick(2);
        cs_n = 1'b1; tick(2);
    endtask

    task automatic expect_status(input string req, input logic [7:0] exp);
        logic [7:0] b;
        read_status(b);
        chk(req, b, exp);
    endtask

    // all bytes of one area equal to val: counted as one check
    task automatic expect_area(input string req, input int area, input logic [7:0] val);
        int bad = 0;
        int first = val;
        for (int a = 0; a < 256; a++) begin
            rd_sel = 2'(area); rd_addr = 8'(a); tick(1);
            if (rd_data != val) begin
                if (bad == 0) first = rd_data;
                bad++;
            end
        end
        chk(req, first, val);
    endtask

    task automatic t_reset;
        chk("R1 so idle", so, 0);
        expect_status("R1 R3 reset status", 8'h10);
        expect_area("R1 area1 zero", 1, 8'h00);
        rd_sel = 2'd0; rd_addr = 8'd3; tick(1);
        chk("R11 sel0 reads zero", rd_data, 0);
    endtask

    task automatic t_no_wel;
        frame(40'h44_001000, 32); tick(E + 20);
        expect_status("R8 no wip without wel", 8'h10);
        expect_area("R8 area1 untouched", 1, 8'h00);
    endtask

    task automatic t_wren;
        frame(40'h06 << 1, 9);
        expect_status("R2 9-bit wren ignored", 8'h10);
        frame(40'h06, 8);
        expect_status("R2 wren sets wel", 8'h12);
    endtask

    task automatic t_bad_addr;
        frame(40'h44_011000, 32);
        frame(40'h44_001100, 32);
        frame(40'h44_000000, 32);
        frame(40'h44_004000, 32);
        tick(E + 20);
        expect_status("R6 bad address keeps wel", 8'h12);
        expect_area("R6 area1 untouched", 1, 8'h00);
        expect_area("R6 area3 untouched", 3, 8'h00);
    endtask

    task automatic t_bitcount;
        frame(40'h44_001000 >> 1, 31);
        frame(40'h44_001000 << 1, 33);
        tick(E + 20);
        expect_status("R7 wrong length ignored", 8'h12);
        expect_area("R7 area1 untouched", 1, 8'h00);
    endtask

    task automatic t_locked;
        frame(40'h44_002000, 32); tick(E + 20);
        expect_status("R9 locked ignored", 8'h12);
        expect_area("R9 area2 untouched", 2, 8'h00);
    endtask

    task automatic t_erase1;
        frame(40'h44_0010A5, 32);
        expect_status("R4 wip set wel cleared", 8'h11);
        frame(40'h06, 8);
        expect_status("R3 status while busy", 8'h11);
        tick(E + 20);
        expect_status("R4 R10 done and wel stays clear", 8'h10);
        expect_area("R5 area1 erased", 1, 8'hFF);
        expect_area("R5 area2 kept", 2, 8'h00);
        expect_area("R5 area3 kept", 3, 8'h00);
    endtask

    task automatic t_erase3;
        frame(40'h06, 8);
        frame(40'h44_0030FF, 32);
        tick(E + 20);
        expect_status("R4 second erase done", 8'h10);
        expect_area("R5 R6 area3 erased", 3, 8'hFF);
        expect_area("R5 area1 still erased", 1, 8'hFF);
        rd_sel = 2'd3; rd_addr = 8'd77; tick(1);
        chk("R11 sideband byte", rd_data, 8'hFF);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_no_wel();
        t_wren();
        t_bad_addr();
        t_bitcount();
        t_locked();
        t_erase1();
        t_erase3();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule